// File: doc/BRIEF.md
# Register-Offset Load Address Generator

This block accepts one 32-bit load instruction of the register-indexed form, splits it into its fields and forms the effective address. The address is a base value plus an index register value. The index is first widened, by sign or by zero extension from its low 32 bits or used whole, and then optionally scaled by the access size. The base is a general register, or the stack pointer when the base field names register 31. The block issues a single memory read and returns the loaded word or doubleword, zero-extended, to the destination register.

The two register-file read ports are combinational. Their indices follow the incoming instruction directly, and the block samples the returned data in the cycle it accepts the instruction. There are two reasons a load does not go to memory. An illegal encoding raises a one-cycle undefined flag. A misaligned stack-pointer base raises a one-cycle alignment fault. The block holds only one memory read at a time and shows busy until the response arrives.

Top module: `ldr_regoff_agu`

## Requirements
- R1: An instruction is legal only if bit31=1, bits[29:27]=111, bit26=0, bits[25:24]=00, bits[23:22]=01, bit21=1 and bits[11:10]=10. Any other instruction raises `undef_flag` for exactly one cycle after acceptance and issues no memory read.
- R2: Option is bits[15:13]. When option bit 1 (instruction bit 14) is 0, the instruction raises `undef_flag` and issues no read. This takes priority over the alignment check.
- R3: The index operand comes from Rm (bits[20:16]) and is set by option. 010 zero-extends its low 32 bits. 110 sign-extends its low 32 bits. 011 and 111 use all 64 bits.
- R4: Bit30 selects the size: 0 gives 4 bytes and scale 2, 1 gives 8 bytes and scale 3. The extended index is shifted left by the scale only when the flag in bit12 is 1. When bit12 is 0 it is not shifted.
- R5: Rn is bits[9:5]. When Rn is not 31, the base is that register. When Rn is 31, the base is `sp_value`.
- R6: When Rn is 31 and the low four bits of `sp_value` are not all zero, `align_fault` pulses for one cycle and no read is issued.
- R7: The address is the 64-bit sum of base and scaled index, modulo 2^64.
- R8: Each legal, aligned instruction produces exactly one request. The request stays asserted with a stable address until `mem_req_ready`. `busy` is high from acceptance until the response. Instructions offered while busy are ignored.
- R9: `mem_req_size` is {1, bit30}: 2 means 4 bytes, 3 means 8 bytes. For a 4-byte load, the upper 32 bits of `wb_data` are zero.
- R10: In the response cycle, `wb_en` is high for one cycle and `wb_idx` equals Rt (bits[4:0]). When Rt is 31, `wb_en` stays low.
- R11: After reset, `busy`, `mem_req_valid`, `wb_en`, `undef_flag` and `align_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_instr | input | 32 | Instruction word |
| busy | output | 1 | A load is in flight; new instructions are not taken |
| rf_base_idx | output | 5 | Read index for the base register |
| rf_base_data | input | 64 | Base register value |
| rf_index_idx | output | 5 | Read index for the index register |
| rf_index_data | input | 64 | Index register value |
| sp_value | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Request taken by memory |
| mem_req_addr | output | 64 | Effective address |
| mem_req_size | output | 2 | Log2 of access bytes |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data |
| wb_en | output | 1 | Destination write strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Zero-extended load result |
| undef_flag | output | 1 | Illegal encoding pulse |
| align_fault | output | 1 | Stack-pointer misalignment pulse |

## Verification
The assertions assume the memory side behaves. It asserts `mem_rsp_valid` only after it has taken a request, and it never asserts it while the request is still pending. The register-file data must settle in the same cycle as the index it answers. The bench meets these conditions. Its register file is a fixed array read combinationally. Its memory model returns a response only after the handshake, with the response data derived from the address.

// File: rtl/ldro_pkg.sv
package ldro_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned OPT_W     = 3;
  localparam logic [REG_IDX_W-1:0] REG_SP_ZR = 5'd31;

  typedef struct packed {
    logic                 legal;
    logic [1:0]           size;
    logic [REG_IDX_W-1:0] rm;
    logic [OPT_W-1:0]     opt;
    logic                 sc;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rt;
  } ld_dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} ld_state_e;
endpackage

// File: rtl/ldro_decode.sv
module ldro_decode
  import ldro_pkg::*;
(
  input  logic [31:0] instr,
  output ld_dec_t     dec
);
  logic pat_ok;

  always_comb begin
    pat_ok = instr[31] && (instr[29:27] == 3'b111) && !instr[26] &&
             (instr[25:24] == 2'b00) && (instr[23:22] == 2'b01) &&
             instr[21] && (instr[11:10] == 2'b10);
    dec.legal = pat_ok && instr[14];
    dec.size  = instr[31:30];
    dec.rm    = instr[20:16];
    dec.opt   = instr[15:13];
    dec.sc    = instr[12];
    dec.rn    = instr[9:5];
    dec.rt    = instr[4:0];
  end
endmodule

// File: rtl/ldro_addr.sv
module ldro_addr
  import ldro_pkg::*;
#(
  parameter int unsigned XLEN          = 64,
  parameter int unsigned SP_ALIGN_BITS = 4
) (
  input  logic [1:0]           size,
  input  logic [OPT_W-1:0]     opt,
  input  logic                 sc,
  input  logic [REG_IDX_W-1:0] rn,
  input  logic [XLEN-1:0]      base_reg,
  input  logic [XLEN-1:0]      index_reg,
  input  logic [XLEN-1:0]      sp,
  output logic [XLEN-1:0]      addr,
  output logic                 sp_misaligned
);
  localparam int unsigned HALF_W = 32;

  logic [XLEN-1:0] ext_v;
  logic [XLEN-1:0] base_v;
  logic [1:0]      shamt;

  always_comb begin
    if (opt[0]) begin
      ext_v = index_reg;
    end else if (opt[2]) begin
      ext_v = {{(XLEN-HALF_W){index_reg[HALF_W-1]}}, index_reg[HALF_W-1:0]};
    end else begin
      ext_v = {{(XLEN-HALF_W){1'b0}}, index_reg[HALF_W-1:0]};
    end
    shamt  = sc ? size : 2'd0;
    base_v = (rn == REG_SP_ZR) ? sp : base_reg;
    addr   = base_v + (ext_v << shamt);
  end

  generate
    if (SP_ALIGN_BITS > 0) begin : g_align
      assign sp_misaligned = (rn == REG_SP_ZR) && (|sp[SP_ALIGN_BITS-1:0]);
    end else begin : g_noalign
      assign sp_misaligned = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ldr_regoff_agu.sv
module ldr_regoff_agu
  import ldro_pkg::*;
#(
  parameter int unsigned XLEN          = 64,
  parameter int unsigned SP_ALIGN_BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  output logic            busy,
  output logic [4:0]      rf_base_idx,
  input  logic [XLEN-1:0] rf_base_data,
  output logic [4:0]      rf_index_idx,
  input  logic [XLEN-1:0] rf_index_data,
  input  logic [XLEN-1:0] sp_value,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [1:0]      mem_req_size,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            wb_en,
  output logic [4:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            undef_flag,
  output logic            align_fault
);
  localparam int unsigned WORD_W = 32;

  ld_dec_t         dec;
  logic [XLEN-1:0] ea;
  logic            misal;

  ld_state_e            state_q, state_d;
  logic [XLEN-1:0]      addr_q;
  logic [1:0]           size_q;
  logic [REG_IDX_W-1:0] rt_q;
  logic                 undef_q, undef_d;
  logic                 fault_q, fault_d;
  logic                 accept, load_en, rsp_fire;

  ldro_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  ldro_addr #(.XLEN(XLEN), .SP_ALIGN_BITS(SP_ALIGN_BITS)) u_addr (
    .size          (dec.size),
    .opt           (dec.opt),
    .sc            (dec.sc),
    .rn            (dec.rn),
    .base_reg      (rf_base_data),
    .index_reg     (rf_index_data),
    .sp            (sp_value),
    .addr          (ea),
    .sp_misaligned (misal)
  );

  assign rf_base_idx  = dec.rn;
  assign rf_index_idx = dec.rm;

  always_comb begin
    accept   = in_valid && (state_q == ST_IDLE);
    load_en  = accept && dec.legal && !misal;
    undef_d  = accept && !dec.legal;
    fault_d  = accept && dec.legal && misal;
    rsp_fire = (state_q == ST_WAIT) && mem_rsp_valid;
    state_d  = state_q;
    case (state_q)
      ST_IDLE: if (load_en)       state_d = ST_REQ;
      ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      rt_q    <= '0;
    end else begin
      state_q <= state_d;
      undef_q <= undef_d;
      fault_q <= fault_d;
      if (load_en) begin
        addr_q <= ea;
        size_q <= dec.size;
        rt_q   <= dec.rt;
      end
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_size  = size_q;
  assign undef_flag    = undef_q;
  assign align_fault   = fault_q;
  assign wb_en         = rsp_fire && (rt_q != REG_SP_ZR);
  assign wb_idx        = rt_q;
  assign wb_data       = size_q[0] ? mem_rsp_data
                                   : {{(XLEN-WORD_W){1'b0}}, mem_rsp_data[WORD_W-1:0]};

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R1
  undef_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> !mem_req_valid && !busy);

  // R6
  fault_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !busy);

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_flag, align_fault, busy}));

  // R10
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !busy);
endmodule

// File: tb/ldr_regoff_agu_tb.sv
module ldr_regoff_agu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // vector layout: [21:17]rt [16:12]rn [11:7]rm [6:4]opt [3]scale flag [2]dword [1:0]kind(0 ok,1 undef)
  localparam logic [21:0] VECS [0:NV-1] = '{
    {5'd1,  5'd2,  5'd3, 3'b011, 1'b0, 1'b1, 2'd0},
    {5'd4,  5'd2,  5'd5, 3'b010, 1'b1, 1'b0, 2'd0},
    {5'd8,  5'd2,  5'd5, 3'b110, 1'b1, 1'b1, 2'd0},
    {5'd9,  5'd31, 5'd6, 3'b111, 1'b0, 1'b0, 2'd0},
    {5'd10, 5'd7,  5'd7, 3'b011, 1'b1, 1'b1, 2'd0},
    {5'd11, 5'd2,  5'd3, 3'b001, 1'b0, 1'b1, 2'd1},
    {5'd12, 5'd2,  5'd3, 3'b100, 1'b1, 1'b0, 2'd1},
    {5'd31, 5'd2,  5'd3, 3'b011, 1'b0, 1'b1, 2'd0},
    {5'd3,  5'd6,  5'd5, 3'b110, 1'b0, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic        busy;
  logic [4:0]  rf_base_idx, rf_index_idx;
  logic [63:0] rf_base_data, rf_index_data, sp_value;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        undef_flag, align_fault;

  logic [63:0] rf [0:31];
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_base_data  = rf[rf_base_idx];
  assign rf_index_data = rf[rf_index_idx];

  ldr_regoff_agu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr), .busy(busy),
    .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
    .rf_index_idx(rf_index_idx), .rf_index_data(rf_index_data), .sp_value(sp_value),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .undef_flag(undef_flag), .align_fault(align_fault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic dw, input logic [4:0] rm, input logic [2:0] opt,
                                     input logic s, input logic [4:0] rn, input logic [4:0] rt);
    return {1'b1, dw, 3'b111, 1'b0, 2'b00, 2'b01, 1'b1, rm, opt, s, 2'b10, rn, rt};
  endfunction

  function automatic logic [63:0] model_addr(input logic [4:0] rn, input logic [4:0] rm,
                                             input logic [2:0] opt, input logic s, input logic dw);
    logic [63:0] b, x;
    b = (rn == 5'd31) ? sp_value : rf[rn];
    case (opt)
      3'b010:  x = {32'h0, rf[rm][31:0]};
      3'b110:  x = {{32{rf[rm][31]}}, rf[rm][31:0]};
      default: x = rf[rm];
    endcase
    if (s) x = x << (dw ? 3 : 2);
    return b + x;
  endfunction

  function automatic logic [63:0] rsp_pat(input logic [63:0] a);
    return {a[31:0] ^ 32'hDEAD_BEEF, ~a[31:0]};
  endfunction

  // kind: 0 = load, 1 = undefined, 2 = alignment fault
  task automatic run_instr(input logic [31:0] ins, input int kind, input logic [63:0] ea,
                           input int stall, input bit intrude, input string tag);
    logic [63:0] d;
    @(negedge clk);
    in_instr = ins; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (kind == 1) begin
      chk({tag, " R1 R2 undef pulse"}, {63'h0, undef_flag}, 64'd1);
      chk({tag, " R2 no read"}, {62'h0, mem_req_valid, align_fault}, 64'd0);
      @(negedge clk);
      chk({tag, " R1 pulse one cycle"}, {62'h0, undef_flag, busy}, 64'd0);
    end else if (kind == 2) begin
      chk({tag, " R6 fault pulse"}, {63'h0, align_fault}, 64'd1);
      chk({tag, " R6 no read"}, {62'h0, mem_req_valid, undef_flag}, 64'd0);
      @(negedge clk);
      chk({tag, " R6 pulse one cycle"}, {62'h0, align_fault, busy}, 64'd0);
    end else begin
      chk({tag, " R8 request"}, {62'h0, mem_req_valid, busy}, 64'd3);
      chk({tag, " R3 R4 R5 R7 address"}, mem_req_addr, ea);
      chk({tag, " R9 size"}, {62'h0, mem_req_size}, {62'h0, 1'b1, ins[30]});
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        chk({tag, " R8 held"}, {63'h0, mem_req_valid}, 64'd1);
        chk({tag, " R8 stable"}, mem_req_addr, ea);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk({tag, " R8 single request busy"}, {62'h0, mem_req_valid, busy}, 64'd1);
      if (intrude) begin
        in_instr = mk(1'b1, 5'd3, 3'b011, 1'b0, 5'd2, 5'd20);
        in_valid = 1'b1;
        @(negedge clk);
        chk({tag, " R8 ignored while busy"}, {62'h0, mem_req_valid, busy}, 64'd1);
      end
      d = rsp_pat(ea);
      mem_rsp_valid = 1'b1; mem_rsp_data = d;
      #1;
      chk({tag, " R10 wb_en"}, {63'h0, wb_en}, {63'h0, (ins[4:0] != 5'd31)});
      if (ins[4:0] != 5'd31) begin
        chk({tag, " R10 wb_idx"}, {59'h0, wb_idx}, {59'h0, ins[4:0]});
        chk({tag, " R9 wb_data"}, wb_data, ins[30] ? d : {32'h0, d[31:0]});
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0; in_valid = 1'b0;
      chk({tag, " R10 one cycle"}, {62'h0, wb_en, busy}, 64'd0);
      @(negedge clk);
      chk({tag, " R8 no extra read"}, {62'h0, mem_req_valid, busy}, 64'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [21:0] v;
    logic [31:0] ins;
    for (int i = 0; i < 32; i++) rf[i] = 64'h0123_4567_0000_0000 + 64'(i) * 64'h10;
    rf[5] = 64'hFFFF_FFFF_8000_0010;
    rf[6] = 64'h0000_0001_FFFF_FFF0;
    rf[7] = 64'hFFFF_FFFF_FFFF_FFF8;
    sp_value = 64'h0000_7FF0_0000_1000;
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {59'h0, busy, mem_req_valid, wb_en, undef_flag, align_fault}, 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      ins = mk(v[2], v[11:7], v[6:4], v[3], v[16:12], v[21:17]);
      run_instr(ins, int'(v[1:0]), model_addr(v[16:12], v[11:7], v[6:4], v[3], v[2]),
                0, 1'b0, $sformatf("vec%0d", k));
    end

    // R1 pattern violation: bit26 set
    ins = mk(1'b1, 5'd3, 3'b011, 1'b0, 5'd2, 5'd1) | 32'h0400_0000;
    run_instr(ins, 1, 64'h0, 0, 1'b0, "R1 bad pattern");
    // R1 bits[11:10] wrong
    ins = mk(1'b1, 5'd3, 3'b011, 1'b0, 5'd2, 5'd1) ^ 32'h0000_0C00;
    run_instr(ins, 1, 64'h0, 0, 1'b0, "R1 bad bits 11:10");
    // R6 misaligned stack pointer
    sp_value = 64'h0000_7FF0_0000_1008;
    run_instr(mk(1'b1, 5'd3, 3'b011, 1'b0, 5'd31, 5'd1), 2, 64'h0, 0, 1'b0, "R6 misaligned sp");
    // R2 priority over alignment
    run_instr(mk(1'b1, 5'd3, 3'b000, 1'b0, 5'd31, 5'd1), 1, 64'h0, 0, 1'b0, "R2 priority");
    // R5 misaligned sp ignored when base is not 31
    run_instr(mk(1'b0, 5'd3, 3'b011, 1'b1, 5'd4, 5'd2), 0,
              model_addr(5'd4, 5'd3, 3'b011, 1'b1, 1'b0), 0, 1'b0, "R5 gpr base");
    sp_value = 64'h0000_7FF0_0000_1000;
    // R8 stall and intruding instruction
    run_instr(mk(1'b1, 5'd5, 3'b111, 1'b1, 5'd2, 5'd6), 0,
              model_addr(5'd2, 5'd5, 3'b111, 1'b1, 1'b1), 3, 1'b1, "R8 stall");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule